// File: doc/BRIEF.md
# Windowed Pipeline Stage Sequencer

This block drives one step of a fixed-latency processing chain. The step reads items from a BX-banked input memory that the upstream step fills, and passes each item through an external combinational function. It writes each result into a BX-banked output memory that the downstream step drains. Every bunch crossing gets a budget of exactly `WIN_LEN` clock cycles, and that budget opens on a start strobe. When the budget runs out, or the next strobe arrives, the sequencer closes the window. Any items it has not read are abandoned, so the chain latency never depends on how many items arrive.

There are two banks per memory. While the upstream step fills the bank for the current BX, this step works on the other bank, which holds the previous BX. The producer supplies a per-bank item count, and the sequencer latches it when the window opens. A result is written `PIPE_LAT` cycles after its item is read. For this reason, reads stop early enough that the last write still lands inside the window.

Top module: `stage_seq`

## Requirements
- R1: While reset is held, rd_en_o, wr_en_o, trunc_o and done_o are all 0.
- R2: A window opened with bx_odd_i = b reads bank (b xor 1), and every write issued for that window carries the same bank.
- R3: A window reads addresses 0, 1, 2, … on consecutive cycles, starting in the cycle after the strobe. Reading stops once the latched item count has been read.
- R4: Each read at address a in cycle c gives a write in cycle c+PIPE_LAT, to address a in the same bank. The write data is fn_res_i as computed from the word the memory returned for that read.
- R5: A window issues at most WIN_LEN−PIPE_LAT reads, so no write falls outside it.
- R6: trunc_o is high for one cycle after a window closes with items still unread, and low after a window that read all its items.
- R7: done_o is high for one cycle after every window closes. In that cycle, done_cnt_o gives the number of reads the window issued.
- R8: Without a strobe, a window closes after WIN_LEN cycles, and no reads occur until the next strobe.
- R9: A strobe inside an open window closes that window at once (R6 and R7 apply to it) and opens a new one.
- R10: The item count is sampled only in the strobe cycle. Changes to in_cnt_i during a window do not affect its reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_start_i | input | 1 | Opens a new window |
| bx_odd_i | input | 1 | Parity of the BX the upstream step is writing |
| in_cnt_i | input | 2*CNT_W | Item counts, bank 0 in the low CNT_W bits |
| rd_en_o | output | 1 | Input memory read enable |
| rd_bank_o | output | 1 | Input memory bank |
| rd_addr_o | output | ADDR_W | Input memory address |
| rd_data_i | input | DATA_W | Read data, one cycle after rd_en_o |
| fn_arg_o | output | DATA_W | Operand to the processing function |
| fn_res_i | input | DATA_W | Result of the processing function |
| wr_en_o | output | 1 | Output memory write enable |
| wr_bank_o | output | 1 | Output memory bank |
| wr_addr_o | output | ADDR_W | Output memory address |
| wr_data_o | output | DATA_W | Output memory write data |
| trunc_o | output | 1 | Closing window left items unread |
| done_o | output | 1 | Window closed |
| done_cnt_o | output | CNT_W | Reads issued by the closed window |

## Verification
The hardest case to reach is a window cut short by an early strobe while reads and writes from it are still in flight. In that case the old bank's results must keep draining while the new window reads the other bank. The stimulus gets there by starting a window with more items than the cycles that pass before the next strobe. It also covers a window whose count exceeds the read budget by one, a window that reads exactly the budget, and a count that changes in the middle of a window.

// File: rtl/stage_seq_pkg.sv
package stage_seq_pkg;
  localparam int unsigned DEF_WIN_LEN  = 36;
  localparam int unsigned DEF_PIPE_LAT = 4;

  // upstream writes bank bx, this stage works on bank bx-1
  function automatic logic read_bank(input logic bx_odd);
    return ~bx_odd;
  endfunction
endpackage

// File: rtl/stage_seq_window.sv
module stage_seq_window #(
  parameter int unsigned WIN_LEN = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic end_o
);
  localparam int unsigned WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);

  logic [WIN_W-1:0] win_q;
  logic             act_q;
  logic             last;

  assign last     = act_q && (win_q == LAST);
  assign active_o = act_q;
  assign end_o    = act_q && (last || start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      win_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      win_q <= '0;
    end else if (last) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/stage_seq_rd.sv
module stage_seq_rd #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned BUDGET = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                bank_sel_i,
  input  logic [2*CNT_W-1:0]  in_cnt_i,
  input  logic                active_i,
  input  logic                end_i,
  output logic                rd_en_o,
  output logic                rd_bank_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic                trunc_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    done_cnt_o
);
  localparam logic [CNT_W-1:0] BUDGET_C = CNT_W'(BUDGET);

  logic [CNT_W-1:0] rp_q, cnt_q, rp_nxt;
  logic             bank_q;

  assign rd_en_o   = active_i && (rp_q < cnt_q) && (rp_q < BUDGET_C);
  assign rd_bank_o = bank_q;
  assign rd_addr_o = rp_q[ADDR_W-1:0];
  assign rp_nxt    = rp_q + CNT_W'(rd_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q   <= '0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (start_i) begin
      rp_q   <= '0;
      cnt_q  <= bank_sel_i ? in_cnt_i[2*CNT_W-1:CNT_W] : in_cnt_i[CNT_W-1:0];
      bank_q <= bank_sel_i;
    end else begin
      rp_q   <= rp_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trunc_o    <= 1'b0;
      done_o     <= 1'b0;
      done_cnt_o <= '0;
    end else begin
      done_o  <= end_i;
      trunc_o <= end_i && (rp_nxt < cnt_q);
      if (end_i) done_cnt_o <= rp_nxt;
    end
  end
endmodule

// File: rtl/stage_seq_pipe.sv
module stage_seq_pipe #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PIPE_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_bank_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] fn_arg_o,
  input  logic [DATA_W-1:0] fn_res_i,
  output logic              wr_en_o,
  output logic              wr_bank_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned DLY = PIPE_LAT - 1;  // one cycle is the memory read

  typedef struct packed {
    logic              vld;
    logic              bank;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ent_t;

  logic              tag_vld;
  logic              tag_bank;
  logic [ADDR_W-1:0] tag_addr;
  ent_t              stg [DLY];

  assign fn_arg_o = rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_vld  <= 1'b0;
      tag_bank <= 1'b0;
      tag_addr <= '0;
    end else begin
      tag_vld  <= rd_en_i;
      tag_bank <= rd_bank_i;
      tag_addr <= rd_addr_i;
    end
  end

  for (genvar i = 0; i < DLY; i++) begin : g_stg
    ent_t src;
    if (i == 0) begin : g_head
      assign src = '{vld: tag_vld, bank: tag_bank, addr: tag_addr, data: fn_res_i};
    end else begin : g_body
      assign src = stg[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= src;
    end
  end

  assign wr_en_o   = stg[DLY-1].vld;
  assign wr_bank_o = stg[DLY-1].bank;
  assign wr_addr_o = stg[DLY-1].addr;
  assign wr_data_o = stg[DLY-1].data;
endmodule

// File: rtl/stage_seq.sv
module stage_seq
  import stage_seq_pkg::*;
#(
  parameter int unsigned WIN_LEN  = DEF_WIN_LEN,
  parameter int unsigned PIPE_LAT = DEF_PIPE_LAT,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned CNT_W   = ADDR_W + 1,
  localparam int unsigned BUDGET  = WIN_LEN - PIPE_LAT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bx_start_i,
  input  logic                bx_odd_i,
  input  logic [2*CNT_W-1:0]  in_cnt_i,
  output logic                rd_en_o,
  output logic                rd_bank_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic [DATA_W-1:0]   fn_arg_o,
  input  logic [DATA_W-1:0]   fn_res_i,
  output logic                wr_en_o,
  output logic                wr_bank_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                trunc_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    done_cnt_o
);
  logic win_active, win_end;

  stage_seq_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (bx_start_i),
    .active_o (win_active),
    .end_o    (win_end)
  );

  stage_seq_rd #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUDGET(BUDGET)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (bx_start_i),
    .bank_sel_i (read_bank(bx_odd_i)),
    .in_cnt_i   (in_cnt_i),
    .active_i   (win_active),
    .end_i      (win_end),
    .rd_en_o    (rd_en_o),
    .rd_bank_o  (rd_bank_o),
    .rd_addr_o  (rd_addr_o),
    .trunc_o    (trunc_o),
    .done_o     (done_o),
    .done_cnt_o (done_cnt_o)
  );

  stage_seq_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE_LAT(PIPE_LAT)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_o),
    .rd_bank_i (rd_bank_o),
    .rd_addr_i (rd_addr_o),
    .rd_data_i (rd_data_i),
    .fn_arg_o  (fn_arg_o),
    .fn_res_i  (fn_res_i),
    .wr_en_o   (wr_en_o),
    .wr_bank_o (wr_bank_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/stage_seq_chk.sv
module stage_seq_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned BUDGET = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bx_start_i,
  input logic              active_i,
  input logic              rd_en_o,
  input logic              rd_bank_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              trunc_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  done_cnt_o
);
  assert_rd_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) && !$past(bx_start_i) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  assert_rd_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o && $past(rd_en_o) && !$past(bx_start_i) |-> $stable(rd_bank_o));

  assert_rd_budget_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> CNT_W'(rd_addr_o) < CNT_W'(BUDGET));

  assert_done_budget_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> done_cnt_o <= CNT_W'(BUDGET));

  assert_trunc_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |-> done_o);

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !rd_en_o);
endmodule

bind stage_seq stage_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUDGET(BUDGET)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bx_start_i (bx_start_i),
  .active_i   (win_active),
  .rd_en_o    (rd_en_o),
  .rd_bank_o  (rd_bank_o),
  .rd_addr_o  (rd_addr_o),
  .trunc_o    (trunc_o),
  .done_o     (done_o),
  .done_cnt_o (done_cnt_o)
);

// File: tb/stage_seq_tb.sv
module stage_seq_tb;
  localparam int WIN = 36, LAT = 4, AW = 6, DW = 16, CW = AW + 1, BUD = WIN - LAT;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, bx_start, bx_odd;
  logic [2*CW-1:0] in_cnt;
  logic rd_en, rd_bank, wr_en, wr_bank, trunc, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, fn_arg, fn_res, wr_data;
  logic [CW-1:0] done_cnt;

  stage_seq #(.WIN_LEN(WIN), .PIPE_LAT(LAT), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bx_start_i(bx_start), .bx_odd_i(bx_odd),
    .in_cnt_i(in_cnt), .rd_en_o(rd_en), .rd_bank_o(rd_bank), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .fn_arg_o(fn_arg), .fn_res_i(fn_res), .wr_en_o(wr_en),
    .wr_bank_o(wr_bank), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .trunc_o(trunc),
    .done_o(done), .done_cnt_o(done_cnt));

  function automatic logic [DW-1:0] memval(int b, int a);
    return DW'(b * 4096 + a * 257 + 51);
  endfunction
  function automatic logic [DW-1:0] fnf(logic [DW-1:0] x);
    return {x[7:0], x[15:8]} ^ 16'h5A5A;
  endfunction

  assign fn_res = fnf(fn_arg);
  always @(posedge clk) if (rd_en) rd_data <= memval(int'(rd_bank), int'(rd_addr));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference
  int m_act = 0, m_win = 0, m_rp = 0, m_cnt = 0, m_bank = 0;
  int e_trunc = 0, e_done = 0, e_dcnt = 0, cyc = 0;
  int q_c[$], q_b[$], q_a[$], q_d[$];

  task automatic step(bit st, bit odd, int c0, int c1);
    int e_rd, rp_n, end_now, e_wr;
    @(negedge clk);
    bx_start = st; bx_odd = odd; in_cnt = {CW'(c1), CW'(c0)};
    e_rd = (m_act != 0 && m_rp < m_cnt && m_rp < BUD) ? 1 : 0;
    chk("R3/R8/R10 rd_en", 32'(rd_en), e_rd);
    if (e_rd != 0) begin
      chk("R2 rd_bank", 32'(rd_bank), m_bank);
      chk("R3 rd_addr", 32'(rd_addr), m_rp);
    end
    e_wr = (q_c.size() > 0 && q_c[0] == cyc) ? 1 : 0;
    chk("R4 wr_en", 32'(wr_en), e_wr);
    if (e_wr != 0) begin
      chk("R2/R4 wr_bank", 32'(wr_bank), q_b[0]);
      chk("R4 wr_addr", 32'(wr_addr), q_a[0]);
      chk("R4 wr_data", 32'(wr_data), q_d[0]);
      void'(q_c.pop_front()); void'(q_b.pop_front());
      void'(q_a.pop_front()); void'(q_d.pop_front());
    end
    chk("R6 trunc", 32'(trunc), e_trunc);
    chk("R7/R9 done", 32'(done), e_done);
    if (e_done != 0) begin
      chk("R7/R9 done_cnt", 32'(done_cnt), e_dcnt);
      chk("R5 budget", 32'(done_cnt <= CW'(BUD)), 1);
    end
    if (e_rd != 0) begin
      q_c.push_back(cyc + LAT); q_b.push_back(m_bank); q_a.push_back(m_rp);
      q_d.push_back(32'(fnf(memval(m_bank, m_rp))));
    end
    rp_n    = m_rp + e_rd;
    end_now = (m_act != 0 && (m_win == WIN - 1 || st)) ? 1 : 0;
    e_done  = end_now;
    if (end_now != 0) e_dcnt = rp_n;
    e_trunc = (end_now != 0 && rp_n < m_cnt) ? 1 : 0;
    if (st) begin
      m_act = 1; m_win = 0; m_rp = 0;
      m_bank = odd ? 0 : 1;
      m_cnt = odd ? c0 : c1;
    end else if (m_act != 0 && m_win == WIN - 1) begin
      m_act = 0;
    end else if (m_act != 0) begin
      m_win++; m_rp = rp_n;
    end
    cyc++;
  endtask

  task automatic window(bit odd, int c0, int c1, int n);
    step(1'b1, odd, c0, c1);
    repeat (n - 1) step(1'b0, odd, c0, c1);
  endtask

  initial begin
    rst_ni = 1'b0; bx_start = 1'b0; bx_odd = 1'b0; in_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_en", 32'(rd_en), 0);
    chk("R1 wr_en", 32'(wr_en), 0);
    chk("R1 trunc", 32'(trunc), 0);
    chk("R1 done", 32'(done), 0);
    rst_ni = 1'b1;
    window(1'b1, 10, 0, WIN);          // bank 0, short
    window(1'b0, 0, 40, WIN);          // bank 1, over budget: R6
    step(1'b1, 1'b1, 7, 0);            // R10: count changes mid-window
    repeat (WIN - 1) step(1'b0, 1'b1, 20, 0);
    repeat (50) step(1'b0, 1'b0, 5, 5); // R8 idle without strobe
    window(1'b0, 0, 30, 15);           // R9: cut short by next strobe
    window(1'b1, 3, 0, WIN);
    window(1'b0, 0, 0, WIN);           // empty window
    window(1'b1, BUD, 0, WIN);         // exactly the budget
    window(1'b0, 0, BUD + 1, WIN);     // one over budget
    repeat (12) step(1'b0, 1'b0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule